// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns IEEE-754 binary floating-point operands into two's-complement signed integers. One 64-bit source word is interpreted in one of two ways. In packed mode it holds two single-precision values, and each becomes its own 32-bit integer in the matching half of the result. In scalar mode the whole word is one double-precision value, and it becomes either a 32-bit or a 64-bit integer.

Rounding is chosen per operation by a 2-bit control input. Results that cannot be represented return a fixed most-negative "indefinite" integer and raise an invalid flag; they are not saturated. Such results come from NaN, infinity, or a magnitude that is too large after rounding. A precision flag reports that a nonzero fraction was dropped. When the invalid condition is unmasked, the block raises an exception request instead of delivering the masked response.

Every operation takes one registered stage: a request accepted on `valid_i` produces its result and flags on the next clock edge.

Top module: `fp_int_cvt`

## Requirements
- R1: `valid_o` follows `valid_i` with one cycle of latency. The result and flags load only on an accepted request and otherwise hold. Asynchronous reset clears every output to zero.
- R2: The rounding control `rc_i` selects the rounding of inexact values: 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 truncates toward zero.
- R3: When `scalar_i`=0, `src_i[31:0]` and `src_i[63:32]` are single-precision values that produce `result_o[31:0]` and `result_o[63:32]` respectively, and `wide_i` has no effect.
- R4: When `scalar_i`=1, `src_i[63:0]` is one double-precision value. With `wide_i`=0 the 32-bit integer appears in `result_o[31:0]` and `result_o[63:32]` is zero. With `wide_i`=1 the full 64-bit integer is returned.
- R5: NaN, infinity, and any value whose rounded result lies outside the signed range of the selected width set `invalid_o`. With `inv_mask_i`=1 the affected field returns the indefinite value: 0x80000000 per 32-bit field, or 0x8000000000000000 for a 64-bit result.
- R6: `precision_o` is set when nonzero fraction bits are discarded and the result is valid. In packed mode it is the OR over the lanes, and an invalid lane suppresses only its own contribution.
- R7: With `inv_mask_i`=0, an invalid operation sets `exc_req_o` and `invalid_o` and clears `precision_o`, and its result is unspecified. With `inv_mask_i`=1, `exc_req_o` never asserts.
- R8: A positive or negative zero converts to 0 with no flags. A subnormal converts to 0, +1 or -1 as the rounding mode directs, and it sets `precision_o`.
- R9: In a 32-bit result, -2^31 is valid and exact. Under nearest-even, 2^31-0.5 rounds to 2^31 and is invalid. Under truncation the same value gives 0x7FFFFFFF with `precision_o` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Conversion request |
| scalar_i | input | 1 | 1: one double-precision value; 0: two single-precision lanes |
| wide_i | input | 1 | Scalar only: 1 selects a 64-bit result, 0 a 32-bit result |
| rc_i | input | 2 | Rounding control (R2 encoding) |
| inv_mask_i | input | 1 | 1 masks invalid (indefinite returned), 0 requests an exception |
| src_i | input | 64 | Source operand |
| valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Integer result(s) |
| invalid_o | output | 1 | Invalid-operation flag |
| precision_o | output | 1 | Inexact-result flag |
| exc_req_o | output | 1 | Unmasked invalid exception request |

## Verification
Some properties are checked on every cycle. These are the one-cycle handshake and the holding of the result while idle. Another is that a masked operation never requests an exception, and that a request always comes with the invalid flag and without precision. A scalar result never carries both invalid and precision. A narrow scalar result has a zero upper half. A double NaN or infinity in 64-bit mode yields the 64-bit indefinite value. Several other behaviours can only be shown by the bench's chosen operands. These are the correctness of the rounded integers in each rounding mode, including ties, and the exact boundaries at ±2^31 and ±2^63. Also in this group are the per-lane flag merging in packed mode and the handling of zeros and subnormals.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } rc_e;
endpackage

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  rc_e  rc_i,
  input  logic sign_i,
  input  logic lsb_i,
  input  logic guard_i,
  input  logic sticky_i,
  output logic inc_o
);
  always_comb begin
    unique case (rc_i)
      RC_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RC_DOWN: inc_o = sign_i & (guard_i | sticky_i);
      RC_UP:   inc_o = ~sign_i & (guard_i | sticky_i);
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
  import fcvt_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int OUT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] fp_i,
  input  rc_e                   rc_i,
  input  logic                  wide_i,
  output logic [OUT_W-1:0]      res_o,
  output logic                  inv_o,
  output logic                  prec_o
);
  localparam int MAN_W = FRAC_W + 1;
  localparam int SW    = OUT_W + MAN_W;
  localparam int SH_W  = $clog2(OUT_W + 1);
  localparam int E_W   = EXP_W + 2;
  localparam int HALF  = OUT_W / 2;
  localparam logic signed [E_W-1:0] BIAS_S = E_W'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [E_W-1:0] EMAX_S = E_W'(OUT_W);
  localparam logic signed [E_W-1:0] EM1_S  = {E_W{1'b1}};
  localparam logic [OUT_W+1:0] LIM_W   = {3'b001, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W+1:0] LIM_N   = {{(HALF+2){1'b0}}, 1'b1, {(HALF-1){1'b0}}};
  localparam logic [OUT_W-1:0] INDEF_W = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] INDEF_N = {{HALF{1'b0}}, 1'b1, {(HALF-1){1'b0}}};

  logic                    sgn;
  logic [EXP_W-1:0]        ex;
  logic [FRAC_W-1:0]       fr;
  logic [MAN_W-1:0]        man;
  logic signed [E_W-1:0]   e_unb;
  logic                    nan_inf, e_big, e_neg;
  logic [SH_W-1:0]         sh;
  logic [SW-1:0]           shifted;
  logic [OUT_W:0]          int_part;
  logic                    guard, sticky, inc, ovf;
  logic [OUT_W+1:0]        mag, lim;
  logic [OUT_W-1:0]        sres;

  assign {sgn, ex, fr} = fp_i;
  assign man     = {|ex, fr};
  assign e_unb   = $signed({2'b00, ex}) - BIAS_S;
  assign nan_inf = &ex;
  assign e_big   = e_unb > EMAX_S;
  assign e_neg   = e_unb[E_W-1];
  assign sh      = (e_neg | e_big) ? '0 : e_unb[SH_W-1:0];
  assign shifted = {{OUT_W{1'b0}}, man} << sh;

  // Split into integer part, first dropped bit and OR of the rest
  always_comb begin
    if (e_neg) begin
      int_part = '0;
      guard    = (e_unb == EM1_S) & man[FRAC_W];
      sticky   = (e_unb == EM1_S) ? |man[FRAC_W-1:0] : |man;
    end else begin
      int_part = shifted[SW-1:FRAC_W];
      guard    = shifted[FRAC_W-1];
      sticky   = |shifted[FRAC_W-2:0];
    end
  end

  fcvt_round u_round (
    .rc_i     (rc_i),
    .sign_i   (sgn),
    .lsb_i    (int_part[0]),
    .guard_i  (guard),
    .sticky_i (sticky),
    .inc_o    (inc)
  );

  assign mag  = {1'b0, int_part} + {{(OUT_W+1){1'b0}}, inc};
  assign lim  = wide_i ? LIM_W : LIM_N;
  // Range is checked after rounding: a carry can push a value out of range
  assign ovf  = e_big | (mag > lim) | (~sgn & (mag == lim));
  assign sres = sgn ? -mag[OUT_W-1:0] : mag[OUT_W-1:0];

  assign inv_o  = nan_inf | ovf;
  assign prec_o = (guard | sticky) & ~inv_o;

  always_comb begin
    if (inv_o)       res_o = wide_i ? INDEF_W : INDEF_N;
    else if (wide_i) res_o = sres;
    else             res_o = {{HALF{1'b0}}, sres[HALF-1:0]};
  end
endmodule

// File: rtl/fp_int_cvt.sv
module fp_int_cvt
  import fcvt_pkg::*;
#(
  parameter int SP_EXP_W  = 8,
  parameter int SP_FRAC_W = 23,
  parameter int DP_EXP_W  = 11,
  parameter int DP_FRAC_W = 52,
  localparam int SP_W     = 1 + SP_EXP_W + SP_FRAC_W,
  localparam int DATA_W   = 1 + DP_EXP_W + DP_FRAC_W,
  localparam int LANES    = DATA_W / SP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              scalar_i,
  input  logic              wide_i,
  input  logic [1:0]        rc_i,
  input  logic              inv_mask_i,
  input  logic [DATA_W-1:0] src_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              invalid_o,
  output logic              precision_o,
  output logic              exc_req_o
);
  rc_e                rc;
  logic [DATA_W-1:0]  sp_res, dp_res, res_n;
  logic [LANES-1:0]   sp_inv, sp_prec;
  logic               dp_inv, dp_prec;
  logic               inv_n, prec_raw, exc_n, prec_n;

  assign rc = rc_e'(rc_i);

  for (genvar g = 0; g < LANES; g++) begin : g_sp
    fcvt_lane #(
      .EXP_W  (SP_EXP_W),
      .FRAC_W (SP_FRAC_W),
      .OUT_W  (SP_W)
    ) u_lane (
      .fp_i   (src_i[g*SP_W +: SP_W]),
      .rc_i   (rc),
      .wide_i (1'b1),
      .res_o  (sp_res[g*SP_W +: SP_W]),
      .inv_o  (sp_inv[g]),
      .prec_o (sp_prec[g])
    );
  end

  fcvt_lane #(
    .EXP_W  (DP_EXP_W),
    .FRAC_W (DP_FRAC_W),
    .OUT_W  (DATA_W)
  ) u_dp (
    .fp_i   (src_i),
    .rc_i   (rc),
    .wide_i (wide_i),
    .res_o  (dp_res),
    .inv_o  (dp_inv),
    .prec_o (dp_prec)
  );

  assign res_n    = scalar_i ? dp_res  : sp_res;
  assign inv_n    = scalar_i ? dp_inv  : |sp_inv;
  assign prec_raw = scalar_i ? dp_prec : |sp_prec;
  assign exc_n    = inv_n & ~inv_mask_i;
  assign prec_n   = prec_raw & ~exc_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      result_o    <= '0;
      invalid_o   <= 1'b0;
      precision_o <= 1'b0;
      exc_req_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o    <= res_n;
        invalid_o   <= inv_n;
        precision_o <= prec_n;
        exc_req_o   <= exc_n;
      end
    end
  end
endmodule

// File: rtl/fp_int_cvt_chk.sv
module fp_int_cvt_chk #(
  parameter int DATA_W   = 64,
  parameter int DP_EXP_W = 11
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                scalar_i,
  input logic                wide_i,
  input logic                inv_mask_i,
  input logic [DP_EXP_W-1:0] dp_exp_i,
  input logic                valid_o,
  input logic [DATA_W-1:0]   result_o,
  input logic                invalid_o,
  input logic                precision_o,
  input logic                exc_req_o
);
  localparam logic [DATA_W-1:0] INDEF64 = {1'b1, {(DATA_W-1){1'b0}}};

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R1
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R1
  AST_HOLD_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(invalid_o));  // R1
  AST_NARROW_ZX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i && !wide_i && inv_mask_i |=> result_o[DATA_W-1:DATA_W/2] == '0);  // R4
  AST_INDEF_SPECIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i && wide_i && inv_mask_i && (&dp_exp_i) |=> invalid_o && result_o == INDEF64);  // R5
  AST_SCALAR_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && scalar_i |=> !(invalid_o && precision_o));  // R6
  AST_MASKED_NO_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && inv_mask_i |=> !exc_req_o);  // R7
  AST_EXC_IMPLIES_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> invalid_o && !precision_o);  // R7
endmodule

bind fp_int_cvt fp_int_cvt_chk #(
  .DATA_W   (DATA_W),
  .DP_EXP_W (DP_EXP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .scalar_i    (scalar_i),
  .wide_i      (wide_i),
  .inv_mask_i  (inv_mask_i),
  .dp_exp_i    (src_i[DATA_W-2 -: DP_EXP_W]),
  .valid_o     (valid_o),
  .result_o    (result_o),
  .invalid_o   (invalid_o),
  .precision_o (precision_o),
  .exc_req_o   (exc_req_o)
);

// File: tb/fp_int_cvt_tb_top.sv
module fp_int_cvt_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        scalar;
    logic        wide;
    logic        mask;
    logic [1:0]  rc;
    logic [63:0] src;
    logic [63:0] res;
    logic        inv;
    logic        prec;
    logic        exc;
    logic        care;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  // scalar, wide, mask, rc, src, expected result, inv, prec, exc, result checked, requirement
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,2'd0,64'hC0200000_40200000,64'hFFFFFFFE_00000002,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2 ties nearest-even
    '{1'b0,1'b0,1'b1,2'd1,64'hC0200000_40200000,64'hFFFFFFFD_00000002,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2 floor
    '{1'b0,1'b0,1'b1,2'd2,64'hC0200000_40200000,64'hFFFFFFFE_00000003,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2 ceil
    '{1'b0,1'b0,1'b1,2'd3,64'hC0200000_40200000,64'hFFFFFFFE_00000002,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2 trunc
    '{1'b0,1'b0,1'b1,2'd0,64'hBF000000_3FC00000,64'h00000000_00000002,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b0,1'b0,1'b1,2'd1,64'hBF000000_3FC00000,64'hFFFFFFFF_00000001,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b0,1'b0,1'b1,2'd2,64'hBF000000_3FC00000,64'h00000000_00000002,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b0,1'b0,1'b1,2'd3,64'hBF000000_3FC00000,64'h00000000_00000001,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b0,1'b1,1'b1,2'd3,64'h3F800000_3FC00000,64'h00000001_00000001,1'b0,1'b1,1'b0,1'b1,4'd3}, // R3 wide ignored
    '{1'b0,1'b0,1'b1,2'd0,64'h3F800000_7FC00000,64'h00000001_80000000,1'b1,1'b0,1'b0,1'b1,4'd5}, // R5 lane NaN
    '{1'b0,1'b0,1'b1,2'd3,64'h3FC00000_7FC00000,64'h00000001_80000000,1'b1,1'b1,1'b0,1'b1,4'd6}, // R6 per-lane
    '{1'b0,1'b0,1'b1,2'd0,64'hCF000000_4F000000,64'h80000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd9}, // R9 +-2^31
    '{1'b1,1'b0,1'b1,2'd0,64'h41DFFFFF_FFE00000,64'h00000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd9}, // R9
    '{1'b1,1'b0,1'b1,2'd3,64'h41DFFFFF_FFE00000,64'h00000000_7FFFFFFF,1'b0,1'b1,1'b0,1'b1,4'd9}, // R9
    '{1'b1,1'b0,1'b1,2'd1,64'h41DFFFFF_FFE00000,64'h00000000_7FFFFFFF,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b1,1'b0,1'b1,2'd2,64'h41DFFFFF_FFE00000,64'h00000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd2}, // R2
    '{1'b1,1'b0,1'b1,2'd0,64'hC1E00000_00000000,64'h00000000_80000000,1'b0,1'b0,1'b0,1'b1,4'd9}, // R9 -2^31
    '{1'b1,1'b0,1'b1,2'd3,64'hC1E00000_00200000,64'h00000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd5}, // R5 -2^31-1
    '{1'b1,1'b0,1'b1,2'd0,64'h00000000_00000000,64'h00000000_00000000,1'b0,1'b0,1'b0,1'b1,4'd8}, // R8 +0
    '{1'b1,1'b0,1'b1,2'd1,64'h80000000_00000000,64'h00000000_00000000,1'b0,1'b0,1'b0,1'b1,4'd8}, // R8 -0
    '{1'b1,1'b0,1'b1,2'd0,64'h00000000_00000001,64'h00000000_00000000,1'b0,1'b1,1'b0,1'b1,4'd8}, // R8 subnormal
    '{1'b1,1'b0,1'b1,2'd2,64'h00000000_00000001,64'h00000000_00000001,1'b0,1'b1,1'b0,1'b1,4'd8}, // R8
    '{1'b1,1'b0,1'b1,2'd1,64'h80000000_00000001,64'h00000000_FFFFFFFF,1'b0,1'b1,1'b0,1'b1,4'd8}, // R8
    '{1'b1,1'b0,1'b1,2'd0,64'hC00E0000_00000000,64'h00000000_FFFFFFFC,1'b0,1'b1,1'b0,1'b1,4'd4}, // R4 -3.75
    '{1'b1,1'b0,1'b1,2'd3,64'hC00E0000_00000000,64'h00000000_FFFFFFFD,1'b0,1'b1,1'b0,1'b1,4'd4}, // R4
    '{1'b1,1'b0,1'b1,2'd0,64'h42700000_00000800,64'h00000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd4}, // R4 2^40+0.5 narrow
    '{1'b1,1'b1,1'b1,2'd0,64'h42700000_00000800,64'h00000100_00000000,1'b0,1'b1,1'b0,1'b1,4'd4}, // R4 wide
    '{1'b1,1'b1,1'b1,2'd2,64'h42700000_00000800,64'h00000100_00000001,1'b0,1'b1,1'b0,1'b1,4'd2}, // R2
    '{1'b1,1'b1,1'b1,2'd0,64'h41DFFFFF_FFE00000,64'h00000000_80000000,1'b0,1'b1,1'b0,1'b1,4'd4}, // R4
    '{1'b1,1'b1,1'b1,2'd3,64'hC1E00000_00200000,64'hFFFFFFFF_7FFFFFFF,1'b0,1'b0,1'b0,1'b1,4'd4}, // R4
    '{1'b1,1'b1,1'b1,2'd1,64'h80000000_00000001,64'hFFFFFFFF_FFFFFFFF,1'b0,1'b1,1'b0,1'b1,4'd8}, // R8
    '{1'b1,1'b1,1'b1,2'd0,64'hC3E00000_00000000,64'h80000000_00000000,1'b0,1'b0,1'b0,1'b1,4'd5}, // R5 -2^63 valid
    '{1'b1,1'b1,1'b1,2'd0,64'h43E00000_00000000,64'h80000000_00000000,1'b1,1'b0,1'b0,1'b1,4'd5}, // R5 2^63
    '{1'b1,1'b1,1'b1,2'd0,64'hFFF00000_00000000,64'h80000000_00000000,1'b1,1'b0,1'b0,1'b1,4'd5}, // R5 -inf
    '{1'b1,1'b0,1'b1,2'd3,64'h7FF80000_00000000,64'h00000000_80000000,1'b1,1'b0,1'b0,1'b1,4'd5}, // R5 NaN
    '{1'b1,1'b1,1'b0,2'd0,64'h7FF00000_00000000,64'h00000000_00000000,1'b1,1'b0,1'b1,1'b0,4'd7}, // R7 unmasked
    '{1'b1,1'b1,1'b0,2'd0,64'h3FF00000_00000000,64'h00000000_00000001,1'b0,1'b0,1'b0,1'b1,4'd7}, // R7
    '{1'b0,1'b0,1'b0,2'd3,64'h3FC00000_7FC00000,64'h00000000_00000000,1'b1,1'b0,1'b1,1'b0,4'd7}, // R7
    '{1'b1,1'b0,1'b0,2'd1,64'h3FF80000_00000000,64'h00000000_00000001,1'b0,1'b1,1'b0,1'b1,4'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, scalar_i = 1'b0, wide_i = 1'b0, inv_mask_i = 1'b1;
  logic [1:0]  rc_i = 2'd0;
  logic [63:0] src_i = '0;
  logic        valid_o, invalid_o, precision_o, exc_req_o;
  logic [63:0] result_o;
  int          checks = 0, fails = 0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_int_cvt dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .scalar_i    (scalar_i),
    .wide_i      (wide_i),
    .rc_i        (rc_i),
    .inv_mask_i  (inv_mask_i),
    .src_i       (src_i),
    .valid_o     (valid_o),
    .result_o    (result_o),
    .invalid_o   (invalid_o),
    .precision_o (precision_o),
    .exc_req_o   (exc_req_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    bit ok;
    @(negedge clk);
    valid_i = 1'b1; scalar_i = v.scalar; wide_i = v.wide;
    inv_mask_i = v.mask; rc_i = v.rc; src_i = v.src;
    @(negedge clk);
    valid_i = 1'b0;
    ok = (valid_o === 1'b1) && (invalid_o === v.inv) && (precision_o === v.prec) &&
         (exc_req_o === v.exc) && (!v.care || result_o === v.res);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d vec %0d: actual res=%h v/i/p/e=%b%b%b%b expected res=%h v/i/p/e=1%b%b%b",
               v.req, idx, result_o, valid_o, invalid_o, precision_o, exc_req_o,
               v.res, v.inv, v.prec, v.exc);
    end
  endtask

  initial begin
    logic [63:0] held;
    #(CLK_PERIOD*2);
    @(negedge clk);
    // R1 reset state
    check({valid_o, invalid_o, precision_o, exc_req_o} === 4'b0 && result_o === '0,
          "R1", "reset outputs", result_o, 64'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1 hold while idle: inputs change without valid_i
    held = result_o;
    @(negedge clk);
    scalar_i = 1'b1; wide_i = 1'b1; inv_mask_i = 1'b1; rc_i = 2'd2;
    src_i = 64'h7FF00000_00000000;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0, "R1", "valid_o idle", {63'b0, valid_o}, 64'h0);
    check(result_o === held && invalid_o === 1'b0 && precision_o === 1'b1,
          "R1", "result held", result_o, held);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    check({valid_o, invalid_o, precision_o, exc_req_o} === 4'b0 && result_o === '0,
          "R1", "async reset", result_o, 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    run_vec(VECS[0], 0);  // R2 after reset release

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule